// File: doc/BRIEF.md
# Key-Locked Scan Segment Gate

This block is a one-bit segment insertion cell for a reconfigurable on-chip scan network. It guards a hidden instrument segment. When the gate is open, the hidden segment is spliced into the active scan path. When the gate is closed, the cell is a single scan bit. The gate opens only if a secret key is present at the update-stage outputs of chosen bits elsewhere in the chain, and only in the same update cycle that writes a 1 into the gate.

One or more trap bits go with the gate. Each trap bit has an update register inside the block, which loads from a shift-stage tap of the chain on every selected update. If any trap register is written with a value other than its safe value, a lock flag is set. The lock forces the gate closed at once and keeps it closed. Only the asynchronous global reset clears the lock.

A field user who does not know the key and the trap values gets one wrong guess before the segment is gone until the next power-up reset. This makes a brute-force search for the key impractical.

Top module: `key_locked_sib`

## Requirements
- R1: While `trst_n` is low and right after reset, the shift flop and the gate are 0. `seg_sel` is 0, `so` and `seg_si` are 0, and `trap_upd` equals the parameter `TRAP_OK` (default 1'b1).
- R2: On a rising `tck` with `sel`=1, `shift_en`=1 and `capture_en`=0, the shift flop loads `si`. While the gate is closed, `so` shows the shift flop.
- R3: On a rising `tck` with `sel`=1 and `capture_en`=1, the shift flop loads the current gate value (1 = open). Capture takes priority over shift.
- R4: An update (rising `tck` with `sel`=1 and `update_en`=1) opens the gate only if all three hold: the shift flop is 1, `key_taps` equals `KEY_VAL` (default 8'hA5), and `trap_taps` equals `TRAP_OK`. While open, `seg_sel`=`sel` and `so`=`seg_ret`.
- R5: An update with `key_taps` different from `KEY_VAL` leaves the gate closed and closes an open gate. A key mismatch alone does not set the lock.
- R6: On every update, the trap update register loads `trap_taps`, and `trap_upd` shows it from the next cycle on.
- R7: An update whose `trap_taps` differ from `TRAP_OK` sets the lock. The gate is closed at that edge.
- R8: While the lock is set, no scan operation opens the gate, including a matching key with a correct trap value. Only a global reset clears the lock.
- R9: With `sel`=0, shift, capture and update requests change neither the shift flop, the gate, the trap register nor the lock.
- R10: `seg_si` always presents the shift flop, so the hidden segment is fed from the gate bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Global asynchronous reset, active low |
| sel | input | 1 | Cell is on the active scan path |
| shift_en | input | 1 | Shift request |
| capture_en | input | 1 | Capture request |
| update_en | input | 1 | Update request |
| si | input | 1 | Scan data in |
| so | output | 1 | Scan data out (gate bit or segment return) |
| seg_sel | output | 1 | Select for the hidden segment |
| seg_si | output | 1 | Scan data toward the hidden segment |
| seg_ret | input | 1 | Scan data returning from the hidden segment |
| key_taps | input | KEY_W | Update-stage values of the designated key bits |
| trap_taps | input | TRAP_N | Shift-stage values of the trap bits |
| trap_upd | output | TRAP_N | Trap update register contents |

## Verification
The in-RTL assertions check on every clock cycle that the lock is sticky and that a locked gate is never open. They also check that a wrong trap write always sets the lock, that the gate moves only on a selected update, and that every opening was preceded by a selected update with a matching key. The bench scenarios are the only place that shows the rest. This includes the data path values: capture of the gate into the shift flop, the `so`/`seg_ret` routing, and trap register contents. It also includes the ordering cases: capture over shift, a mismatch closing an open gate without locking, and the reset bringing the gate back into service.

// File: rtl/klsib_pkg.sv
package klsib_pkg;
   typedef enum logic {
      GATE_CLOSED = 1'b0,
      GATE_OPEN   = 1'b1
   } gate_e;

   typedef enum logic [1:0] {
      SOP_HOLD    = 2'd0,
      SOP_SHIFT   = 2'd1,
      SOP_CAPTURE = 2'd2
   } shift_op_e;

   function automatic shift_op_e pick_shift_op(input logic sel, input logic shift_en,
                                               input logic capture_en);
      if (sel && capture_en)    return SOP_CAPTURE;
      else if (sel && shift_en) return SOP_SHIFT;
      else                      return SOP_HOLD;
   endfunction
endpackage

// File: rtl/klsib_shift_cell.sv
module klsib_shift_cell
   import klsib_pkg::*;
(
   input  logic tck,
   input  logic trst_n,
   input  logic sel,
   input  logic shift_en,
   input  logic capture_en,
   input  logic si,
   input  logic cap_val,
   output logic shift_q
);
   shift_op_e op;

   always_comb op = pick_shift_op(sel, shift_en, capture_en);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         shift_q <= 1'b0;
      end else begin
         case (op)
            SOP_CAPTURE: shift_q <= cap_val;
            SOP_SHIFT:   shift_q <= si;
            default:     shift_q <= shift_q;
         endcase
      end
   end

   AST_SHIFT_IDLE_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
      !sel |=> $stable(shift_q)) else $error("shift flop moved while deselected"); // R9
endmodule

// File: rtl/klsib_key_match.sv
module klsib_key_match #(
   parameter int unsigned          KEY_W   = 8,
   parameter logic [KEY_W-1:0]     KEY_VAL = 8'hA5
) (
   input  logic [KEY_W-1:0] key_taps,
   output logic             key_ok
);
   logic [KEY_W-1:0] bit_ok;

   for (genvar i = 0; i < KEY_W; i++) begin : g_bit
      assign bit_ok[i] = ~(key_taps[i] ^ KEY_VAL[i]);
   end

   if (KEY_W == 1) begin : g_single
      assign key_ok = bit_ok[0];
   end else begin : g_reduce
      assign key_ok = &bit_ok;
   end
endmodule

// File: rtl/klsib_trap_guard.sv
module klsib_trap_guard #(
   parameter int unsigned       TRAP_N  = 1,
   parameter logic [TRAP_N-1:0] TRAP_OK = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              upd_strobe,
   input  logic [TRAP_N-1:0] trap_taps,
   output logic [TRAP_N-1:0] trap_q,
   output logic              wrong_now,
   output logic              lock_q
);
   logic [TRAP_N-1:0] bit_bad;

   for (genvar i = 0; i < TRAP_N; i++) begin : g_trap
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)         trap_q[i] <= TRAP_OK[i];
         else if (upd_strobe) trap_q[i] <= trap_taps[i];
      end
      assign bit_bad[i] = trap_taps[i] ^ TRAP_OK[i];
   end

   assign wrong_now = upd_strobe && (|bit_bad);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        lock_q <= 1'b0;
      else if (wrong_now) lock_q <= 1'b1;
   end

   AST_LOCK_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
      lock_q |=> lock_q) else $error("lock cleared without reset"); // R8
   AST_BAD_TRAP_LOCKS: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_strobe && trap_taps != TRAP_OK) |=> lock_q) else $error("wrong trap write did not lock"); // R7
   AST_TRAP_IDLE_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
      !upd_strobe |=> $stable(trap_q)) else $error("trap register moved without update"); // R6
endmodule

// File: rtl/klsib_update_cell.sv
module klsib_update_cell
   import klsib_pkg::*;
(
   input  logic  tck,
   input  logic  trst_n,
   input  logic  upd_strobe,
   input  logic  load_ok,
   input  logic  force_close,
   input  logic  shift_q,
   output gate_e upd_q
);
   gate_e upd_d;

   always_comb begin
      if (force_close)     upd_d = GATE_CLOSED;
      else if (upd_strobe) upd_d = load_ok ? gate_e'(shift_q) : GATE_CLOSED;
      else                 upd_d = upd_q;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) upd_q <= GATE_CLOSED;
      else         upd_q <= upd_d;
   end

   AST_GATE_MOVES_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
      !upd_strobe |=> $stable(upd_q)) else $error("gate moved without update"); // R9
endmodule

// File: rtl/key_locked_sib.sv
module key_locked_sib
   import klsib_pkg::*;
#(
   parameter int unsigned       KEY_W   = 8,
   parameter logic [KEY_W-1:0]  KEY_VAL = 8'hA5,
   parameter int unsigned       TRAP_N  = 1,
   parameter logic [TRAP_N-1:0] TRAP_OK = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              sel,
   input  logic              shift_en,
   input  logic              capture_en,
   input  logic              update_en,
   input  logic              si,
   output logic              so,
   output logic              seg_sel,
   output logic              seg_si,
   input  logic              seg_ret,
   input  logic [KEY_W-1:0]  key_taps,
   input  logic [TRAP_N-1:0] trap_taps,
   output logic [TRAP_N-1:0] trap_upd
);
   localparam int unsigned KEY_MAX_W = 64;

   if (KEY_W < 1 || KEY_W > KEY_MAX_W) begin : g_bad_key_w
      $error("KEY_W must lie in 1..64");
   end
   if (TRAP_N < 1 || TRAP_N > 32) begin : g_bad_trap_n
      $error("TRAP_N must lie in 1..32");
   end

   logic  shift_q;
   logic  upd_strobe;
   logic  key_ok;
   logic  trap_wrong;
   logic  lock_q;
   gate_e upd_q;

   assign upd_strobe = sel && update_en;

   klsib_shift_cell u_shift (
      .tck        (tck),
      .trst_n     (trst_n),
      .sel        (sel),
      .shift_en   (shift_en),
      .capture_en (capture_en),
      .si         (si),
      .cap_val    (upd_q == GATE_OPEN),
      .shift_q    (shift_q)
   );

   klsib_key_match #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_key (
      .key_taps (key_taps),
      .key_ok   (key_ok)
   );

   klsib_trap_guard #(.TRAP_N(TRAP_N), .TRAP_OK(TRAP_OK)) u_trap (
      .tck        (tck),
      .trst_n     (trst_n),
      .upd_strobe (upd_strobe),
      .trap_taps  (trap_taps),
      .trap_q     (trap_upd),
      .wrong_now  (trap_wrong),
      .lock_q     (lock_q)
   );

   klsib_update_cell u_upd (
      .tck         (tck),
      .trst_n      (trst_n),
      .upd_strobe  (upd_strobe),
      .load_ok     (key_ok),
      .force_close (lock_q || trap_wrong),
      .shift_q     (shift_q),
      .upd_q       (upd_q)
   );

   assign seg_si  = shift_q;
   assign seg_sel = sel && (upd_q == GATE_OPEN);
   assign so      = (upd_q == GATE_OPEN) ? seg_ret : shift_q;

   AST_LOCKED_IS_CLOSED: assert property (@(posedge tck) disable iff (!trst_n)
      lock_q |-> (upd_q == GATE_CLOSED)) else $error("gate open while locked"); // R8
   AST_OPEN_NEEDS_KEY: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_q == GATE_OPEN) && $past(upd_q == GATE_CLOSED) |-> $past(upd_strobe && key_ok))
      else $error("gate opened without matching key"); // R4
   AST_MISMATCH_CLOSES: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_strobe && !key_ok) |=> (upd_q == GATE_CLOSED)) else $error("gate open after key mismatch"); // R5
endmodule

// File: tb/key_locked_sib_tb.sv
module key_locked_sib_tb_top;
   localparam int CLK_P = 10;
   localparam logic [7:0] KEY = 8'hA5;
   localparam logic       TOK = 1'b1;

   logic tck = 1'b0, trst_n = 1'b0;
   logic sel = 0, shift_en = 0, capture_en = 0, update_en = 0, si = 0, seg_ret = 0;
   logic [7:0] key_taps = 8'h00;
   logic [0:0] trap_taps = 1'b1;
   logic so, seg_sel, seg_si;
   logic [0:0] trap_upd;

   int checks = 0, fails = 0;
   bit done = 0;

   logic m_shift, m_upd, m_lock, m_trap;

   always #(CLK_P/2) tck = ~tck;

   key_locked_sib dut_i (
      .tck(tck), .trst_n(trst_n), .sel(sel), .shift_en(shift_en), .capture_en(capture_en),
      .update_en(update_en), .si(si), .so(so), .seg_sel(seg_sel), .seg_si(seg_si),
      .seg_ret(seg_ret), .key_taps(key_taps), .trap_taps(trap_taps), .trap_upd(trap_upd)
   );

   function automatic logic exp_so();    return m_upd ? seg_ret : m_shift; endfunction
   function automatic logic exp_seg_sel(); return sel && m_upd;          endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "so", so, exp_so());
      chk(req, "seg_sel", seg_sel, exp_seg_sel());
      chk(req, "seg_si", seg_si, m_shift);
      chk(req, "trap_upd", trap_upd[0], m_trap);
   endtask

   task automatic model_clock();
      logic ns, nu, nl, nt, wrong;
      ns = m_shift; nu = m_upd; nl = m_lock; nt = m_trap; wrong = 0;
      if (sel && capture_en)    ns = m_upd;
      else if (sel && shift_en) ns = si;
      if (sel && update_en) begin
         nt = trap_taps[0];
         wrong = (trap_taps[0] != TOK);
         if (wrong) nl = 1'b1;
         nu = (key_taps == KEY && !wrong) ? m_shift : 1'b0;
      end
      if (nl) nu = 1'b0;
      m_shift = ns; m_upd = nu; m_lock = nl; m_trap = nt;
   endtask

   task automatic do_reset(input string req);
      trst_n = 1'b0;
      m_shift = 0; m_upd = 0; m_lock = 0; m_trap = TOK;
      #1;
      chk(req, "so in reset", so, 1'b0);
      chk(req, "seg_sel in reset", seg_sel, 1'b0);
      chk(req, "trap_upd in reset", trap_upd[0], TOK);
      @(negedge tck);
      trst_n = 1'b1;
   endtask

   task automatic step(input logic s, input logic sh, input logic ca, input logic up,
                       input logic d, input logic [7:0] k, input logic t, input logic r,
                       input string req);
      sel = s; shift_en = sh; capture_en = ca; update_en = up; si = d;
      key_taps = k; trap_taps[0] = t; seg_ret = r;
      @(posedge tck);
      model_clock();
      @(negedge tck);
      check_all(req);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge tck);
      do_reset("R1");
      step(0, 0, 0, 0, 0, 8'h00, 1, 0, "R1");
      chk("R1", "so after reset", so, 1'b0);
      // R2 shifting, R10 seg_si follows shift flop
      step(1, 1, 0, 0, 1, 8'h00, 1, 0, "R2");
      chk("R2", "so after shift 1", so, 1'b1);
      step(1, 1, 0, 0, 0, 8'h00, 1, 1, "R2");
      step(1, 1, 0, 0, 1, 8'h00, 1, 0, "R10");
      chk("R10", "seg_si", seg_si, 1'b1);
      // R4 opening with key
      step(1, 0, 0, 1, 0, KEY, 1, 1, "R4");
      chk("R4", "seg_sel open", seg_sel, 1'b1);
      chk("R4", "so from seg_ret", so, 1'b1);
      step(1, 0, 0, 0, 0, KEY, 1, 0, "R4");
      chk("R4", "so follows seg_ret", so, 1'b0);
      // R3 capture wins over shift
      step(1, 1, 0, 0, 0, KEY, 1, 0, "R2");
      step(1, 1, 1, 0, 0, KEY, 1, 0, "R3");
      chk("R3", "captured gate", seg_si, 1'b1);
      // R9 deselected requests ignored
      step(0, 1, 0, 1, 0, 8'h00, 0, 0, "R9");
      chk("R9", "trap untouched", trap_upd[0], 1'b1);
      sel = 1; #1;
      chk("R9", "gate still open", seg_sel, 1'b1);
      // R5 mismatch closes without lock
      step(1, 0, 0, 1, 1, 8'h5A, 1, 0, "R5");
      chk("R5", "closed on mismatch", seg_sel, 1'b0);
      step(1, 1, 0, 0, 1, 8'h5A, 1, 0, "R5");
      step(1, 0, 0, 1, 1, KEY, 1, 0, "R5");
      chk("R5", "reopens, no lock", seg_sel, 1'b1);
      // R7 wrong trap with good key: locks and closes, R6 trap register
      step(1, 0, 0, 1, 1, KEY, 0, 0, "R7");
      chk("R7", "closed by trap", seg_sel, 1'b0);
      chk("R6", "trap register", trap_upd[0], 1'b0);
      // R8 lock persists
      step(1, 1, 0, 0, 1, KEY, 1, 0, "R8");
      step(1, 0, 0, 1, 1, KEY, 1, 1, "R8");
      chk("R8", "stays closed", seg_sel, 1'b0);
      chk("R6", "trap reload", trap_upd[0], 1'b1);
      do_reset("R8");
      step(1, 1, 0, 0, 1, KEY, 1, 0, "R8");
      step(1, 0, 0, 1, 1, KEY, 1, 0, "R8");
      chk("R8", "opens after reset", seg_sel, 1'b1);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] k;
         int op;
         if ($urandom_range(0, 199) == 0) do_reset("R8");
         op = $urandom_range(0, 3);
         k = ($urandom_range(0, 9) < 7) ? KEY : 8'($urandom);
         step($urandom_range(0, 7) != 0, op == 1, op == 2, op == 3,
              1'($urandom), k, $urandom_range(0, 49) != 0, 1'($urandom), "R4");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule